// File: doc/BRIEF.md
# Periodic Loaded-Battery Test Sequencer

This block decides when a backup cell is put under a test load and what the result means. While main power is good, a scheduler places a resistive load on the cell at regular intervals. During each load window, a synchronized comparator reports whether the loaded cell voltage has dropped below its threshold. A failed test raises a low-battery warning. The warning output is active low and drives an open-drain pad.

The warning is sticky. It survives further failed tests, tests that pass without a cell swap, and power loss. It clears only when three things happen in order: the cell is removed, it stays absent for at least a minimum time, and a later test passes. While the warning is raised, tests repeat on a short period so that a swap is noticed quickly. Each power-up triggers a fresh test after a short recovery delay.

A freshness-seal flag keeps the backup supply path off from first cell attachment (reset) until main power is first seen good. All durations are parameters counted in ticks of a slow timebase input.

Top module: `batt_test_seq`

## Requirements
- R1: From reset `backup_en` is 0. It goes to 1 on the first clock edge at which `pwr_good` is 1, and then stays 1 until the next reset.
- R2: On each rise of `pwr_good`, `load_en` goes high after RECOVERY_TICKS+1 clock edges with `tick` high: one edge to arm the scheduler, then RECOVERY_TICKS ticks. This holds whatever the warning state is.
- R3: Each test keeps `load_en` high for exactly PULSE_TICKS ticks.
- R4: While the warning is clear, `load_en` falls at the end of a test and rises again NORMAL_TICKS ticks later.
- R5: If `batt_low` is 1 at a clock edge while `load_en` is 1, `warn_n` is 0 after that edge.
- R6: While the warning is set, `load_en` falls at the end of a test and rises again WARN_TICKS ticks later.
- R7: Once set, `warn_n` stays 0 through failed tests, through passing tests that follow no valid swap, and through loss and return of `pwr_good`.
- R8: A swap is valid only if `batt_present` stays 0 for at least DETACH_TICKS ticks before it returns to 1. A shorter absence leaves no valid swap. Any failing sample during a load window also cancels a recorded swap.
- R9: A test that ends with no failing sample, coming after a valid swap, drives `warn_n` back to 1. The NORMAL_TICKS period then applies again.
- R10: `load_en` is never 1 while `pwr_good` is 0. Losing power aborts a test in progress and stops the schedule.
- R11: In a cycle with `tick` at 0, no timer advances. A load window in progress stays open, and `load_en` only rises in a cycle that follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (first cell attachment) |
| tick | input | 1 | Single-cycle timebase strobe; all durations count these |
| pwr_good | input | 1 | Main supply above trip point, synchronized |
| batt_low | input | 1 | Comparator: loaded cell below threshold, synchronized |
| batt_present | input | 1 | Cell attached, debounced |
| load_en | output | 1 | Connect test load to the cell |
| warn_n | output | 1 | Low-battery warning, active low (open-drain enable) |
| backup_en | output | 1 | Freshness seal released; backup path may be used |

## Verification
The assertions rely on several properties of the inputs. `pwr_good`, `batt_low` and `batt_present` are already synchronous to `clk`. `tick` is a strobe sampled only at clock edges. `batt_low` has meaning only inside a load window. The stimulus respects these assumptions: every input changes on the falling clock edge, `tick` is held high except in the intervals where freezing is under test, and `batt_low` is raised only inside a load window or while the cell is absent. Under these conditions, every rise and fall of the outputs can be traced to a cause one edge earlier, and the bench predicts each edge by counting ticks from the requirements.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_LOAD
  } phase_e;

  // Interval to the next test, chosen by the warning state that follows the test.
  function automatic int unsigned pick_period(input logic warn,
                                              input int unsigned normal_t,
                                              input int unsigned warn_t);
    return warn ? warn_t : normal_t;
  endfunction

  // A cell absence counts as a swap only if it lasted long enough.
  function automatic logic absence_ok(input int unsigned absent_t,
                                      input int unsigned min_t);
    return absent_t >= min_t;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bts_scheduler.sv
module bts_scheduler
  import bts_pkg::*;
#(
  parameter int unsigned NORMAL_TICKS   = 86400000,
  parameter int unsigned WARN_TICKS     = 5000,
  parameter int unsigned PULSE_TICKS    = 1000,
  parameter int unsigned RECOVERY_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_good,
  input  logic warn_next,
  output logic load_q,
  output logic test_done
);

  localparam int unsigned MAXT = max3(NORMAL_TICKS, WARN_TICKS,
                                      max3(PULSE_TICKS, RECOVERY_TICKS, 1));
  localparam int unsigned CW   = $clog2(MAXT + 1);

  phase_e        phase;
  logic [CW-1:0] remain;
  logic          at_last;

  assign at_last   = (remain <= CW'(1));
  assign load_q    = (phase == PH_LOAD);
  assign test_done = (phase == PH_LOAD) && pwr_good && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (!pwr_good) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase  <= PH_WAIT;
          remain <= CW'(RECOVERY_TICKS);
        end
        PH_WAIT: begin
          if (tick) begin
            if (at_last) begin
              phase  <= PH_LOAD;
              remain <= CW'(PULSE_TICKS);
            end else begin
              remain <= remain - CW'(1);
            end
          end
        end
        PH_LOAD: begin
          if (tick) begin
            if (at_last) begin
              phase  <= PH_WAIT;
              remain <= CW'(pick_period(warn_next, NORMAL_TICKS, WARN_TICKS));
            end else begin
              remain <= remain - CW'(1);
            end
          end
        end
        default: begin
          phase  <= PH_IDLE;
          remain <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/bts_detach_mon.sv
module bts_detach_mon
  import bts_pkg::*;
#(
  parameter int unsigned DETACH_TICKS = 7000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic present,
  input  logic clear,
  output logic swap_ok
);

  localparam int unsigned DW = $clog2(DETACH_TICKS + 1);

  logic          present_q;
  logic [DW-1:0] absent_cnt;
  logic          ok_q;
  logic          detach_evt;
  logic          attach_evt;

  assign detach_evt = present_q & ~present;
  assign attach_evt = ~present_q & present;
  assign swap_ok    = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q  <= 1'b1;
      absent_cnt <= '0;
    end else begin
      present_q <= present;
      if (detach_evt)
        absent_cnt <= '0;
      else if (!present && tick && (absent_cnt < DW'(DETACH_TICKS)))
        absent_cnt <= absent_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ok_q <= 1'b0;
    else if (clear || detach_evt)
      ok_q <= 1'b0;
    else if (attach_evt)
      ok_q <= absence_ok(32'(absent_cnt), DETACH_TICKS);
  end

endmodule

// File: rtl/bts_warn_eval.sv
module bts_warn_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic load_q,
  input  logic batt_low,
  input  logic test_done,
  input  logic swap_ok,
  output logic warn,
  output logic warn_next,
  output logic clear_swap
);

  logic fail_seen;
  logic fail_hit;
  logic pass_clear;

  assign fail_hit   = load_q & pwr_good & batt_low;
  assign pass_clear = test_done & ~fail_hit & ~fail_seen & warn & swap_ok;
  assign warn_next  = fail_hit ? 1'b1 : (pass_clear ? 1'b0 : warn);
  assign clear_swap = fail_hit | pass_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn      <= 1'b0;
      fail_seen <= 1'b0;
    end else begin
      warn <= warn_next;
      if (!pwr_good || test_done)
        fail_seen <= 1'b0;
      else if (fail_hit)
        fail_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/batt_test_seq.sv
module batt_test_seq #(
  parameter int unsigned NORMAL_TICKS   = 86400000,
  parameter int unsigned WARN_TICKS     = 5000,
  parameter int unsigned PULSE_TICKS    = 1000,
  parameter int unsigned DETACH_TICKS   = 7000,
  parameter int unsigned RECOVERY_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_good,
  input  logic batt_low,
  input  logic batt_present,
  output logic load_en,
  output logic warn_n,
  output logic backup_en
);

  logic load_q;
  logic test_done;
  logic warn;
  logic warn_next;
  logic clear_swap;
  logic swap_ok;
  logic sealed;

  bts_scheduler #(
    .NORMAL_TICKS  (NORMAL_TICKS),
    .WARN_TICKS    (WARN_TICKS),
    .PULSE_TICKS   (PULSE_TICKS),
    .RECOVERY_TICKS(RECOVERY_TICKS)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pwr_good (pwr_good),
    .warn_next(warn_next),
    .load_q   (load_q),
    .test_done(test_done)
  );

  bts_warn_eval u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .load_q    (load_q),
    .batt_low  (batt_low),
    .test_done (test_done),
    .swap_ok   (swap_ok),
    .warn      (warn),
    .warn_next (warn_next),
    .clear_swap(clear_swap)
  );

  bts_detach_mon #(
    .DETACH_TICKS(DETACH_TICKS)
  ) u_detach (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .present(batt_present),
    .clear  (clear_swap),
    .swap_ok(swap_ok)
  );

  // Freshness seal: armed by reset, released once by the first good supply.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sealed <= 1'b1;
    else if (pwr_good)
      sealed <= 1'b0;
  end

  assign backup_en = ~sealed;
  assign warn_n    = ~warn;
  assign load_en   = load_q & pwr_good;

endmodule

// File: rtl/bts_checker.sv
module bts_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pwr_good,
  input logic batt_low,
  input logic load_en,
  input logic warn_n,
  input logic backup_en,
  input logic test_done,
  input logic swap_ok
);

  a_r10_load_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> pwr_good)
    else $error("load enabled without power");

  a_r5_warn_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> $past(load_en && batt_low))
    else $error("warning raised without failing loaded sample");

  a_r9_clear_needs_swap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> $past(swap_ok && test_done))
    else $error("warning cleared without valid swap and finished test");

  a_r1_seal_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    backup_en |=> backup_en)
    else $error("freshness seal re-armed without reset");

  a_r1_seal_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_en) |-> $past(pwr_good))
    else $error("seal released without good power");

  a_r11_load_starts_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> $past(tick))
    else $error("load window opened without a tick");

endmodule

bind batt_test_seq bts_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .pwr_good (pwr_good),
  .batt_low (batt_low),
  .load_en  (load_en),
  .warn_n   (warn_n),
  .backup_en(backup_en),
  .test_done(test_done),
  .swap_ok  (swap_ok)
);

// File: tb/batt_test_seq_test.sv
`timescale 1ns/1ps
module batt_test_seq_test;

  localparam int unsigned NT = 20;
  localparam int unsigned WT = 6;
  localparam int unsigned PT = 3;
  localparam int unsigned DT = 4;
  localparam int unsigned RT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic pwr_good = 1'b0;
  logic batt_low = 1'b0;
  logic batt_present = 1'b1;
  logic load_en, warn_n, backup_en;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  batt_test_seq #(
    .NORMAL_TICKS(NT), .WARN_TICKS(WT), .PULSE_TICKS(PT),
    .DETACH_TICKS(DT), .RECOVERY_TICKS(RT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good),
    .batt_low(batt_low), .batt_present(batt_present),
    .load_en(load_en), .warn_n(warn_n), .backup_en(backup_en)
  );

  typedef struct packed {
    logic       pwr;
    logic       low;
    logic       pres;
    logic [7:0] n;
    logic       e_load;
    logic       e_warn_n;
    logic       e_bk;
    logic [7:0] req;
  } row_t;

  // Each row: drive inputs, advance n edges (tick always high), check outputs.
  localparam row_t ROWS [0:20] = '{
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b0, 1'b1, 1'b1, 8'd1},  // R1 seal released
    '{1'b1, 1'b0, 1'b1, 8'd2,  1'b1, 1'b1, 1'b1, 8'd2},  // R2 first test after power-up
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b1, 1'b1, 8'd3},  // R3 window ends after PT
    '{1'b1, 1'b0, 1'b1, 8'd19, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 still waiting
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b1, 8'd4},  // R4 next test at NT
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 8'd5},  // R5 failing sample
    '{1'b1, 1'b0, 1'b1, 8'd2,  1'b0, 1'b0, 1'b1, 8'd5},  // R5 warning held
    '{1'b1, 1'b0, 1'b1, 8'd6,  1'b1, 1'b0, 1'b1, 8'd6},  // R6 retest at WT
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 1'b1, 8'd7},  // R7 pass without swap
    '{1'b1, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b1, 8'd8},  // R8 short detach
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 1'b1, 8'd8},  // R8 reattached early
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 8'd6},  // R6 retest
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0, 1'b1, 8'd8},  // R8 short swap invalid
    '{1'b1, 1'b1, 1'b0, 8'd6,  1'b1, 1'b0, 1'b1, 8'd6},  // R6 long detach, test opens
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b1, 1'b1, 8'd9},  // R9 valid swap + pass clears
    '{1'b1, 1'b0, 1'b1, 8'd19, 1'b0, 1'b1, 1'b1, 8'd9},  // R9 normal period back
    '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b1, 8'd9},  // R9 test at NT
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 1'b1, 1'b1, 8'd10}, // R10 power loss aborts
    '{1'b0, 1'b0, 1'b1, 8'd10, 1'b0, 1'b1, 1'b1, 8'd10}, // R10 suspended
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 1'b1, 1'b1, 8'd2},  // R2 retest on power-up
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b1, 1'b1, 8'd3}   // R3 window length
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic until_load(input logic val, output int n);
    n = 0;
    while (load_en !== val && n < 200) begin
      cycles(1);
      n++;
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    cycles(3);
    chk("R1", "reset backup_en", backup_en, 0);
    chk("R1", "reset warn_n", warn_n, 1);
    chk("R10", "reset load_en", load_en, 0);
    rst_n = 1'b1;
    cycles(2);
    chk("R1", "sealed without power", backup_en, 0);

    for (int i = 0; i < 21; i++) begin
      string tag;
      pwr_good     = ROWS[i].pwr;
      batt_low     = ROWS[i].low;
      batt_present = ROWS[i].pres;
      cycles(int'(ROWS[i].n));
      tag = $sformatf("R%0d/row%0d", ROWS[i].req, i);
      chk(tag, "load_en", load_en, ROWS[i].e_load);
      chk(tag, "warn_n", warn_n, ROWS[i].e_warn_n);
      chk(tag, "backup_en", backup_en, ROWS[i].e_bk);
    end

    // R4 and R11: interval, then freeze inside a window
    until_load(1'b1, n);
    chk("R4", "normal interval", n, NT);
    tick = 1'b0;
    cycles(10);
    chk("R11", "window held with tick low", load_en, 1);
    tick = 1'b1;
    until_load(1'b0, n);
    chk("R3", "window ticks after freeze", n, PT);

    // R5, R7, R2, R6: warning across power loss
    until_load(1'b1, n);
    batt_low = 1'b1;
    cycles(1);
    chk("R5", "warn after failing sample", warn_n, 0);
    batt_low = 1'b0;
    until_load(1'b0, n);
    pwr_good = 1'b0;
    cycles(5);
    chk("R7", "warn kept through power loss", warn_n, 0);
    chk("R10", "no load while unpowered", load_en, 0);
    pwr_good = 1'b1;
    until_load(1'b1, n);
    chk("R2", "power-up test delay", n, RT + 1);
    until_load(1'b0, n);
    chk("R7", "power-up pass without swap", warn_n, 0);
    until_load(1'b1, n);
    chk("R6", "warning interval", n, WT);

    // R1: reset re-arms the seal
    rst_n = 1'b0;
    #1;
    chk("R1", "reset re-arms seal", backup_en, 0);
    chk("R1", "reset clears warning", warn_n, 1);
    chk("R10", "reset drops load", load_en, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule